// File: doc/BRIEF.md
# GPS Timed Frame Release Gate

This block decides, frame by frame, when a buffered transmission frame may go on air in a single frequency network. Every transmitter in the network must put a given frame on air at the same instant. Each transmitter therefore holds its frames until GPS-disciplined local time reaches the time carried in the frame header plus a configurable delay. A sub-second counter advances on a tick enable equal to one 156.25 ns step. On every 1PPS pulse the counter returns to zero and takes the GPS seconds value, which gives the block its local time.

The frame buffer presents the frame at the head of its queue together with that frame's seconds and sub-second fields. The gate adds the delay to the header time, with the delay saturated at 15.999 s, and compares the sum with local time. When the two are equal it releases the frame. While the sum is still ahead of local time the head is held. When the sum is already behind local time the frame is discarded, at no more than twice the normal frame rate. A one-clock indicator follows each release. The transmit enable can be made to depend on GPS lock. Until a 1PPS pulse arrives with lock present, the gate neither releases nor discards anything.

Top module: `frgate_top`

## Requirements
- R1: The sub-second counter increments on each cycle with `tickEn` high and wraps from TICKS_PER_SEC-1 to 0, incrementing the seconds count. A `ppsIn` pulse forces the sub-second count to 0 and loads `gpsSec` into the seconds count, taking priority over a tick in the same cycle.
- R2: Scheduled time in ticks equals frameSec*TICKS_PER_SEC + frameSub + delay. The delay is `delayTicks` limited to DELAY_MAX_TICKS, which by default is 102393600, equal to 15.999 s at 6.4 MHz.
- R3: `frameRelease` is high in a cycle when the gate is synchronised, `frameValid` is high and local time in ticks (seconds*TICKS_PER_SEC + sub-second) equals the scheduled time.
- R4: While the scheduled time is later than local time, neither `frameRelease` nor `frameDrop` is raised, so the head frame is held.
- R5: When the gate is synchronised, `frameValid` is high, local time is later than the scheduled time and the discard pacing window is open, `frameDrop` is high.
- R6: A discard closes the pacing window for FRAME_TICKS/2 ticks. Discards are therefore at least half a frame period apart, which is twice the normal frame rate.
- R7: The gate becomes synchronised on a `ppsIn` pulse while `gpsLock` is high, and loses synchronisation whenever `gpsLock` is low. While it is not synchronised, `frameRelease` and `frameDrop` stay low.
- R8: `txEnable` is a register that, one cycle later, equals NOT(`lockReq` AND NOT `gpsLock`).
- R9: `frameMark` is high for exactly the cycle after each cycle in which `frameRelease` is high.
- R10: During and directly after reset, `frameRelease`, `frameDrop`, `txEnable` and `frameMark` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | One-clock enable per 156.25 ns time step |
| ppsIn | input | 1 | One-clock pulse marking the start of a GPS second |
| gpsSec | input | SEC_W | GPS seconds value loaded on `ppsIn` |
| gpsLock | input | 1 | GPS reference reports lock |
| lockReq | input | 1 | Require lock for transmit enable |
| delayTicks | input | DLY_W | Delay added to frame time, in ticks |
| frameValid | input | 1 | A frame is waiting at the buffer head |
| frameSec | input | SEC_W | Seconds field of the head frame |
| frameSub | input | clog2(TICKS_PER_SEC) | Sub-second field of the head frame, in ticks |
| frameRelease | output | 1 | Head frame goes on air now and is consumed |
| frameDrop | output | 1 | Head frame is late and is discarded |
| txEnable | output | 1 | Transmit enable |
| frameMark | output | 1 | Pulse one cycle after each release |

## Verification
The assertions take for granted that `ppsIn` lasts one clock, that the frame head fields stay stable while `frameValid` is high and no release or discard has happened, and that the frame seconds do not straddle a wrap of the seconds counter. The stimulus raises a pulse for one cycle and changes the head only after a consume strobe. It keeps all seconds values small enough that the seconds count never wraps. The stimulus covers a frame that waits before the first pulse, frames released on time, a burst of late frames and a delay request above the limit. It also covers loss and return of lock with lock required and with lock not required.

// File: rtl/frgate_pkg.sv
package frgate_pkg;

  // Control to datapath strobes
  typedef struct packed {
    logic releaseStb;
    logic dropStb;
  } gateStrobe_t;

  // Datapath to control status
  typedef struct packed {
    logic synced;
    logic due;
    logic late;
    logic gapOpen;
  } gateStatus_t;

endpackage

// File: rtl/frgate_timebase.sv
module frgate_timebase #(
  parameter int SEC_W         = 32,
  parameter int TICKS_PER_SEC = 6400000,
  localparam int SUB_W        = $clog2(TICKS_PER_SEC)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             ppsIn,
  input  logic [SEC_W-1:0] gpsSec,
  input  logic             gpsLock,
  output logic [SUB_W-1:0] subCnt,
  output logic [SEC_W-1:0] secCnt,
  output logic             synced
);

  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(TICKS_PER_SEC - 1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      subCnt <= '0;
      secCnt <= '0;
    end else if (ppsIn) begin
      subCnt <= '0;
      secCnt <= gpsSec;
    end else if (tickEn) begin
      if (subCnt == SUB_LAST) begin
        subCnt <= '0;
        secCnt <= secCnt + 1'b1;
      end else begin
        subCnt <= subCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)          synced <= 1'b0;
    else if (!gpsLock)  synced <= 1'b0;
    else if (ppsIn)     synced <= 1'b1;
  end

  assert_pps_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    ppsIn |=> (subCnt == '0));

  assert_sub_range_R1: assert property (@(posedge clk) disable iff (!rstN)
    subCnt <= SUB_LAST);

  assert_lock_loss_R7: assert property (@(posedge clk) disable iff (!rstN)
    !gpsLock |=> !synced);

endmodule

// File: rtl/frgate_datapath.sv
module frgate_datapath
  import frgate_pkg::*;
#(
  parameter int SEC_W           = 32,
  parameter int TICKS_PER_SEC   = 6400000,
  parameter int FRAME_TICKS     = 614400,
  parameter int DLY_W           = 27,
  parameter int DELAY_MAX_TICKS = 102393600,
  localparam int SUB_W          = $clog2(TICKS_PER_SEC)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             ppsIn,
  input  logic [SEC_W-1:0] gpsSec,
  input  logic             gpsLock,
  input  logic [DLY_W-1:0] delayTicks,
  input  logic [SEC_W-1:0] frameSec,
  input  logic [SUB_W-1:0] frameSub,
  input  gateStrobe_t      strobe,
  output gateStatus_t      status
);

  localparam int WIDE_W    = (SUB_W > DLY_W) ? SUB_W : DLY_W;
  localparam int TIME_W    = SEC_W + WIDE_W + 2;
  localparam int GAP_TICKS = FRAME_TICKS / 2;
  localparam int GAP_W     = $clog2(GAP_TICKS + 1);
  localparam logic [DLY_W-1:0] DLY_LIMIT = DLY_W'(DELAY_MAX_TICKS);

  logic [SUB_W-1:0]  subCnt;
  logic [SEC_W-1:0]  secCnt;
  logic              synced;
  logic [DLY_W-1:0]  effDelay;
  logic [TIME_W-1:0] nowTime;
  logic [TIME_W-1:0] schedTime;
  logic [GAP_W-1:0]  gapCnt;

  frgate_timebase #(
    .SEC_W         (SEC_W),
    .TICKS_PER_SEC (TICKS_PER_SEC)
  ) timebase_i (
    .clk     (clk),
    .rstN    (rstN),
    .tickEn  (tickEn),
    .ppsIn   (ppsIn),
    .gpsSec  (gpsSec),
    .gpsLock (gpsLock),
    .subCnt  (subCnt),
    .secCnt  (secCnt),
    .synced  (synced)
  );

  // Delay limited to the maximum
  always_comb begin
    effDelay = (delayTicks > DLY_LIMIT) ? DLY_LIMIT : delayTicks;
  end

  always_comb begin
    nowTime   = TIME_W'(secCnt) * TIME_W'(TICKS_PER_SEC) + TIME_W'(subCnt);
    schedTime = TIME_W'(frameSec) * TIME_W'(TICKS_PER_SEC) + TIME_W'(frameSub)
              + TIME_W'(effDelay);
  end

  // Discard pacing window
  always_ff @(posedge clk) begin
    if (!rstN)                          gapCnt <= '0;
    else if (strobe.dropStb)            gapCnt <= GAP_W'(GAP_TICKS);
    else if (tickEn && gapCnt != '0)    gapCnt <= gapCnt - 1'b1;
  end

  always_comb begin
    status.synced  = synced;
    status.due     = (nowTime == schedTime);
    status.late    = (nowTime > schedTime);
    status.gapOpen = (gapCnt == '0);
  end

  assert_gap_closes_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dropStb |=> !status.gapOpen);

  assert_delay_limit_R2: assert property (@(posedge clk) disable iff (!rstN)
    effDelay <= DLY_LIMIT);

endmodule

// File: rtl/frgate_control.sv
module frgate_control
  import frgate_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameValid,
  input  logic        lockReq,
  input  logic        gpsLock,
  input  gateStatus_t status,
  output gateStrobe_t strobe,
  output logic        frameRelease,
  output logic        frameDrop,
  output logic        txEnable,
  output logic        frameMark
);

  logic armed;

  always_comb begin
    armed             = frameValid && status.synced;
    strobe.releaseStb = armed && status.due;
    strobe.dropStb    = armed && status.late && status.gapOpen;
    frameRelease      = strobe.releaseStb;
    frameDrop         = strobe.dropStb;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txEnable  <= 1'b0;
      frameMark <= 1'b0;
    end else begin
      txEnable  <= !(lockReq && !gpsLock);
      frameMark <= strobe.releaseStb;
    end
  end

  assert_one_decision_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(frameRelease && frameDrop));

  assert_unsynced_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    !status.synced |-> !(frameRelease || frameDrop));

  assert_mark_follows_R9: assert property (@(posedge clk) disable iff (!rstN)
    frameRelease |=> frameMark);

  assert_tx_gated_R8: assert property (@(posedge clk) disable iff (!rstN)
    (lockReq && !gpsLock) |=> !txEnable);

endmodule

// File: rtl/frgate_top.sv
module frgate_top
  import frgate_pkg::*;
#(
  parameter int SEC_W           = 32,
  parameter int TICKS_PER_SEC   = 6400000,
  parameter int FRAME_TICKS     = 614400,
  parameter int DLY_W           = 27,
  parameter int DELAY_MAX_TICKS = 102393600
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             tickEn,
  input  logic                             ppsIn,
  input  logic [SEC_W-1:0]                 gpsSec,
  input  logic                             gpsLock,
  input  logic                             lockReq,
  input  logic [DLY_W-1:0]                 delayTicks,
  input  logic                             frameValid,
  input  logic [SEC_W-1:0]                 frameSec,
  input  logic [$clog2(TICKS_PER_SEC)-1:0] frameSub,
  output logic                             frameRelease,
  output logic                             frameDrop,
  output logic                             txEnable,
  output logic                             frameMark
);

  gateStrobe_t strobe;
  gateStatus_t status;

  frgate_datapath #(
    .SEC_W           (SEC_W),
    .TICKS_PER_SEC   (TICKS_PER_SEC),
    .FRAME_TICKS     (FRAME_TICKS),
    .DLY_W           (DLY_W),
    .DELAY_MAX_TICKS (DELAY_MAX_TICKS)
  ) datapath_i (
    .clk        (clk),
    .rstN       (rstN),
    .tickEn     (tickEn),
    .ppsIn      (ppsIn),
    .gpsSec     (gpsSec),
    .gpsLock    (gpsLock),
    .delayTicks (delayTicks),
    .frameSec   (frameSec),
    .frameSub   (frameSub),
    .strobe     (strobe),
    .status     (status)
  );

  frgate_control control_i (
    .clk          (clk),
    .rstN         (rstN),
    .frameValid   (frameValid),
    .lockReq      (lockReq),
    .gpsLock      (gpsLock),
    .status       (status),
    .strobe       (strobe),
    .frameRelease (frameRelease),
    .frameDrop    (frameDrop),
    .txEnable     (txEnable),
    .frameMark    (frameMark)
  );

endmodule

// File: tb/frgate_top_tb_top.sv
module frgate_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int SEC_W  = 8;
  localparam int TPS    = 50;
  localparam int FRAME  = 8;
  localparam int DLY_W  = 8;
  localparam int DMAX   = 100;
  localparam int SUB_W  = $clog2(TPS);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b0;
  logic ppsIn = 1'b0;
  logic [SEC_W-1:0] gpsSec = '0;
  logic gpsLock = 1'b0;
  logic lockReq = 1'b0;
  logic [DLY_W-1:0] delayTicks = '0;
  logic frameValid = 1'b0;
  logic [SEC_W-1:0] frameSec = '0;
  logic [SUB_W-1:0] frameSub = '0;
  logic frameRelease, frameDrop, txEnable, frameMark;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  // Frame queue: each entry is sec*1000 + sub
  int fq[$];

  // Reference model state
  int mSec = 0, mSub = 0, mGap = 0;
  bit mSynced = 0, mTx = 0, mMark = 0;

  // Observation counters
  int relCnt = 0, dropCnt = 0, cyc = 0, lastDrop = -1000, minDropGap = 1000000;

  always #(CLK_PERIOD/2) clk = ~clk;

  frgate_top #(
    .SEC_W(SEC_W), .TICKS_PER_SEC(TPS), .FRAME_TICKS(FRAME),
    .DLY_W(DLY_W), .DELAY_MAX_TICKS(DMAX)
  ) dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .ppsIn(ppsIn), .gpsSec(gpsSec),
    .gpsLock(gpsLock), .lockReq(lockReq), .delayTicks(delayTicks),
    .frameValid(frameValid), .frameSec(frameSec), .frameSub(frameSub),
    .frameRelease(frameRelease), .frameDrop(frameDrop), .txEnable(txEnable),
    .frameMark(frameMark)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic void refreshHead();
    if (fq.size() > 0) begin
      frameValid = 1'b1;
      frameSec   = SEC_W'(fq[0] / 1000);
      frameSub   = SUB_W'(fq[0] % 1000);
    end else begin
      frameValid = 1'b0;
    end
  endfunction

  // Expected decisions from model state and current inputs (R2, R3, R5)
  function automatic void calc(output bit eRel, output bit eDrop);
    longint nowT, schedT, d;
    eRel = 0; eDrop = 0;
    if (mSynced && fq.size() > 0) begin
      d = (delayTicks > DMAX) ? DMAX : delayTicks;
      nowT = longint'(mSec) * TPS + mSub;
      schedT = longint'(fq[0] / 1000) * TPS + (fq[0] % 1000) + d;
      eRel = (nowT == schedT);
      eDrop = (nowT > schedT) && (mGap == 0);
    end
  endfunction

  // Model update at the clock edge
  always @(posedge clk) begin
    bit eRel, eDrop;
    if (!rstN) begin
      mSec = 0; mSub = 0; mGap = 0; mSynced = 0; mTx = 0; mMark = 0;
    end else begin
      calc(eRel, eDrop);
      mTx = !(lockReq && !gpsLock);
      mMark = eRel;
      if (eDrop) mGap = FRAME / 2;
      else if (tickEn && mGap > 0) mGap--;
      if (ppsIn) begin mSub = 0; mSec = gpsSec; end
      else if (tickEn) begin
        if (mSub == TPS - 1) begin mSub = 0; mSec = (mSec + 1) % 256; end
        else mSub++;
      end
      if (!gpsLock) mSynced = 0;
      else if (ppsIn) mSynced = 1;
      if (eRel || eDrop) void'(fq.pop_front());
    end
    #1;
    tickEn = ~tickEn;
    refreshHead();
  end

  // Per-cycle comparison away from the edge
  always @(negedge clk) begin
    bit eRel, eDrop;
    if (rstN && !done) begin
      cyc++;
      calc(eRel, eDrop);
      chk("R1,R3 release", int'(frameRelease), int'(eRel));
      chk("R5,R6 drop", int'(frameDrop), int'(eDrop));
      chk("R8 txEnable", int'(txEnable), int'(mTx));
      chk("R9 frameMark", int'(frameMark), int'(mMark));
      if (frameRelease) relCnt++;
      if (frameDrop) begin
        if (cyc - lastDrop < minDropGap) minDropGap = cyc - lastDrop;
        lastDrop = cyc;
        dropCnt++;
      end
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic pulsePps(input int s);
    @(posedge clk); #2;
    ppsIn = 1'b1; gpsSec = SEC_W'(s);
    @(posedge clk); #2;
    ppsIn = 1'b0;
  endtask

  task automatic push(input int s, input int sub);
    fq.push_back(s * 1000 + sub);
    refreshHead();
  endtask

  task automatic waitEmpty(input int maxCyc);
    for (int i = 0; i < maxCyc && fq.size() > 0; i++) cycles(1);
  endtask

  initial begin
    int r0, d0;
    // R10: reset state
    cycles(3);
    chk("R10 release in reset", int'(frameRelease), 0);
    chk("R10 drop in reset", int'(frameDrop), 0);
    chk("R10 txEnable in reset", int'(txEnable), 0);
    chk("R10 frameMark in reset", int'(frameMark), 0);
    rstN = 1'b1;
    cycles(1);
    chk("R10 txEnable after reset", int'(txEnable), 1);

    // R7: a frame whose time is reached and passed, but no PPS yet
    push(0, 0);
    cycles(30);
    chk("R7 no release before PPS", relCnt, 0);
    chk("R7 no drop before PPS", dropCnt, 0);
    chk("R7 frame held", fq.size(), 1);

    // Lock and first PPS: stale frame dropped, then on-time frames
    delayTicks = 8'd10;
    gpsLock = 1'b1;
    pulsePps(5);
    cycles(2);
    chk("R5 stale frame dropped", dropCnt, 1);
    push(5, 20);
    push(5, 28);
    cycles(10);
    chk("R4 frame waits", relCnt, 0);
    chk("R4 frame still queued", fq.size(), 2);
    waitEmpty(200);
    chk("R3 two releases", relCnt, 2);

    // Late burst: paced discards (R6)
    d0 = dropCnt;
    for (int i = 0; i < 4; i++) push(2, i);
    waitEmpty(200);
    chk("R5 late burst dropped", dropCnt - d0, 4);
    chk("R6 drop spacing >= 8 clocks", int'(minDropGap >= 8), 1);

    // Delay request above maximum is limited (R2)
    r0 = relCnt;
    delayTicks = 8'd200;
    push(6, 10);
    waitEmpty(600);
    chk("R2 saturated delay release", relCnt - r0, 1);

    // Lock loss with lock required (R7, R8)
    r0 = relCnt;
    d0 = dropCnt;
    delayTicks = 8'd0;
    lockReq = 1'b1;
    push(20, 3);
    gpsLock = 1'b0;
    cycles(2);
    chk("R8 txEnable low without lock", int'(txEnable), 0);
    cycles(20);
    chk("R7 no release without lock", relCnt - r0, 0);
    chk("R7 no drop without lock", dropCnt - d0, 0);
    gpsLock = 1'b1;
    cycles(2);
    chk("R8 txEnable back with lock", int'(txEnable), 1);
    cycles(10);
    chk("R7 still waiting for PPS", relCnt - r0, 0);
    pulsePps(20);
    waitEmpty(60);
    chk("R1 release after PPS reload", relCnt - r0, 1);

    // Lock not required: txEnable stays high (R8)
    lockReq = 1'b0;
    gpsLock = 1'b0;
    cycles(3);
    chk("R8 txEnable without lock requirement", int'(txEnable), 1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule